// File: doc/BRIEF.md
# Keypad Autorepeat Event Generator

This block sits between a debounced key-matrix event detector and the key-event FIFO. While at least one key stays held, it produces one reserved repeat code word at a steady period. Any new press or release event stops the current repeat count. If keys are still down after that event, the count starts again from the beginning. The number of keys held does not change the output: one shared repeat code covers all of them.

Time is counted in millisecond ticks from the surrounding logic. The repeat period is `(rate + 1) * 40` ticks. The first repeat after a sequence starts waits the same full period as every later one. If the FIFO is full when a repeat falls due, that repeat is dropped and is not held for later. The next repeat comes one full period afterwards.

Top module: `key_repeat_gen`

## Requirements
- R1: While reset is active and after it is released, `rep_push` is 0 and `rep_code` is 0 until a repeat falls due.
- R2: Each repeat is a single push. `rep_push` is high for exactly one clock cycle. During that cycle `rep_code` equals the reserved value 8'hFF, which lies outside the key-number range 0 to 127. In every other cycle `rep_code` is 0.
- R3: The repeat period is `(ar_ctrl[4:1] + 1) * 40` millisecond ticks. The count starts from the first tick after the sequence starts. The first repeat also waits one full period.
- R4: While keys stay held and no event arrives, repeats continue once per period. `rep_push` rises in the clock cycle right after the tick that completes the period.
- R5: A press event (`key_press`) restarts the repeat count from zero.
- R6: A release event (`key_release`) restarts the count from zero if `any_held` stays 1. If `any_held` is 0, no repeat is produced.
- R7: When `ar_ctrl[0]` (enable) is 0, no repeats are produced and the count is cleared. After enable is set again, a full period passes before the next repeat.
- R8: A repeat that falls due while `fifo_full` is 1 is dropped. The next repeat comes one full period later.
- R9: No repeat is produced in a cycle that follows a cycle without a millisecond tick, or a cycle with a press or release event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| ar_ctrl | input | 5 | Bit 0: enable. Bits 4:1: repeat rate |
| key_press | input | 1 | Debounced key press event, one cycle |
| key_release | input | 1 | Debounced key release event, one cycle |
| any_held | input | 1 | At least one key is currently held |
| fifo_full | input | 1 | The key-event FIFO cannot accept a push |
| rep_push | output | 1 | One-cycle push request for a repeat code |
| rep_code | output | 8 | Repeat code word, valid while `rep_push` is 1 |

## Verification
The assertions check on every cycle that a push is a single cycle and carries the reserved code. They also check that every push follows a tick cycle in which the block was enabled, keys were held, the FIFO had room and no event arrived. Only the bench scenarios can show the exact period for each rate value, the restart after press and release events, and that a dropped repeat is not queued but followed one full period later. The bench checks these against a tick-level model of the requirements.

// File: rtl/key_repeat_pkg.sv
package key_repeat_pkg;
  localparam int unsigned KR_CODE_W  = 8;
  localparam logic [KR_CODE_W-1:0] KR_REPEAT_CODE = 8'hFF;
  localparam int unsigned KR_RATE_W  = 4;
  localparam int unsigned KR_MS_UNIT = 40;
endpackage

// File: rtl/kr_rst_sync.sv
module kr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/kr_period.sv
module kr_period #(
  parameter int unsigned RATE_W  = 4,
  parameter int unsigned MS_UNIT = 40,
  parameter int unsigned CNT_W   = 10
) (
  input  logic [RATE_W-1:0] rate,
  output logic [CNT_W-1:0]  period_m1
);
  // Last count value of a period: (rate + 1) * MS_UNIT - 1
  always_comb begin
    period_m1 = CNT_W'((32'(rate) + 32'd1) * 32'(MS_UNIT) - 32'd1);
  end
endmodule

// File: rtl/kr_timer.sv
module kr_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] period_m1,
  output logic             due
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q >= period_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart) begin
      cnt_d = '0;
    end else if (tick) begin
      if (last) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign due = run && !restart && tick && last;
endmodule

// File: rtl/key_repeat_gen.sv
module key_repeat_gen
  import key_repeat_pkg::*;
#(
  parameter int unsigned RATE_W  = KR_RATE_W,
  parameter int unsigned MS_UNIT = KR_MS_UNIT,
  parameter int unsigned CODE_W  = KR_CODE_W,
  parameter logic [CODE_W-1:0] REPEAT_CODE = KR_REPEAT_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [RATE_W:0]   ar_ctrl,
  input  logic              key_press,
  input  logic              key_release,
  input  logic              any_held,
  input  logic              fifo_full,
  output logic              rep_push,
  output logic [CODE_W-1:0] rep_code
);
  localparam int unsigned MAX_PERIOD = MS_UNIT << RATE_W;
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD);

  logic             srst_n;
  logic             enable, run, restart, due;
  logic [CNT_W-1:0] period_m1;
  logic             push_q, push_d;

  kr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  kr_period #(.RATE_W(RATE_W), .MS_UNIT(MS_UNIT), .CNT_W(CNT_W)) u_period (
    .rate      (ar_ctrl[RATE_W:1]),
    .period_m1 (period_m1)
  );

  assign enable  = ar_ctrl[0];
  assign run     = enable && any_held;
  assign restart = key_press || key_release;

  kr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (srst_n),
    .run       (run),
    .restart   (restart),
    .tick      (ms_tick),
    .period_m1 (period_m1),
    .due       (due)
  );

  // A due repeat is dropped when the FIFO is full
  always_comb begin
    push_d = due && !fifo_full;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) push_q <= 1'b0;
    else         push_q <= push_d;
  end

  assign rep_push = push_q;
  assign rep_code = push_q ? REPEAT_CODE : '0;
endmodule

// File: rtl/key_repeat_gen_chk.sv
module key_repeat_gen_chk #(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned CODE_W = 8,
  parameter logic [CODE_W-1:0] REPEAT_CODE = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_tick,
  input logic [RATE_W:0]   ar_ctrl,
  input logic              key_press,
  input logic              key_release,
  input logic              any_held,
  input logic              fifo_full,
  input logic              rep_push,
  input logic [CODE_W-1:0] rep_code
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push |=> !rep_push); // R2
  AST_CODE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push |-> rep_code == REPEAT_CODE); // R2
  AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_push |-> rep_code == '0); // R2
  AST_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push |-> $past(ms_tick)); // R9
  AST_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push |-> !$past(key_press || key_release)); // R9
  AST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push |-> $past(any_held)); // R6
  AST_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push |-> $past(ar_ctrl[0])); // R7
  AST_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rep_push |-> !$past(fifo_full)); // R8
endmodule

bind key_repeat_gen key_repeat_gen_chk #(
  .RATE_W(RATE_W), .CODE_W(CODE_W), .REPEAT_CODE(REPEAT_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ar_ctrl(ar_ctrl),
  .key_press(key_press), .key_release(key_release), .any_held(any_held),
  .fifo_full(fifo_full), .rep_push(rep_push), .rep_code(rep_code)
);

// File: tb/key_repeat_gen_tb_top.sv
module key_repeat_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic [4:0] ar_ctrl = '0;
  logic       key_press = 1'b0, key_release = 1'b0, any_held = 1'b0, fifo_full = 1'b0;
  logic       rep_push;
  logic [7:0] rep_code;

  typedef struct { bit exp; string req; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  int m = 0;
  string cur_req = "R3";
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_repeat_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ar_ctrl(ar_ctrl),
    .key_press(key_press), .key_release(key_release), .any_held(any_held),
    .fifo_full(fifo_full), .rep_push(rep_push), .rep_code(rep_code)
  );

  function automatic bit running();
    return ar_ctrl[0] && any_held;
  endfunction

  // Driver: one tick plus the expected outcome from the requirement model
  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      ms_tick = 1'b1;
      e.exp = 1'b0;
      e.req = cur_req;
      if (running()) begin
        m++;
        if (m >= (int'(ar_ctrl[4:1]) + 1) * UNIT) begin
          m = 0;
          e.exp = !fifo_full;
        end
      end else begin
        m = 0;
      end
      exp_q.push_back(e);
      @(negedge clk);
      ms_tick = 1'b0;
    end
  endtask

  task automatic event_pulse(bit press, bit rel, bit held_after);
    @(negedge clk);
    key_press = press;
    key_release = rel;
    any_held = held_after;
    m = 0;
    @(negedge clk);
    key_press = 1'b0;
    key_release = 1'b0;
  endtask

  task automatic set_cfg(bit en, logic [3:0] rate);
    @(negedge clk);
    ar_ctrl = {rate, en};
    if (!running()) m = 0;
    @(negedge clk);
  endtask

  // Monitor: compares the push after each tick, and checks silence otherwise
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (ms_tick) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL %s: push after tick with empty queue, actual %0b expected queued item", cur_req, rep_push);
        end else begin
          e = exp_q.pop_front();
          n_chk++;
          if (rep_push !== e.exp) begin
            n_fail++;
            $display("FAIL %s: rep_push actual %0b expected %0b", e.req, rep_push, e.exp);
          end
          if (e.exp) begin
            n_chk++;
            if (rep_code !== 8'hFF) begin
              n_fail++;
              $display("FAIL R2: rep_code actual %h expected ff", rep_code);
            end
          end
        end
      end else if (rep_push !== 1'b0 || rep_code !== 8'h00) begin
        n_chk++; n_fail++;
        $display("FAIL R9: push in non-tick cycle, actual %0b/%h expected 0/00", rep_push, rep_code);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (rep_push !== 1'b0 || rep_code !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: in reset actual %0b/%h expected 0/00", rep_push, rep_code);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (rep_push !== 1'b0 || rep_code !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: after reset actual %0b/%h expected 0/00", rep_push, rep_code);
    end
    mon_on = 1'b1;

    // R3 R4: rate 0, pushes at ticks 40 and 80
    cur_req = "R4";
    set_cfg(1'b1, 4'd0);
    event_pulse(1'b1, 1'b0, 1'b1);
    tick_n(100);

    // R3: rate 3 gives 160 ticks
    cur_req = "R3";
    set_cfg(1'b1, 4'd3);
    event_pulse(1'b1, 1'b0, 1'b1);
    tick_n(170);
    set_cfg(1'b1, 4'd0);

    // R5: press mid-period restarts the count
    cur_req = "R5";
    event_pulse(1'b1, 1'b0, 1'b1);
    tick_n(25);
    event_pulse(1'b1, 1'b0, 1'b1);
    tick_n(45);

    // R6: release with keys still held restarts; release with none held stops
    cur_req = "R6";
    tick_n(10);
    event_pulse(1'b0, 1'b1, 1'b1);
    tick_n(45);
    event_pulse(1'b0, 1'b1, 1'b0);
    tick_n(60);

    // R7: disabled gives nothing; re-enable needs a full period
    cur_req = "R7";
    set_cfg(1'b0, 4'd0);
    event_pulse(1'b1, 1'b0, 1'b1);
    tick_n(60);
    set_cfg(1'b1, 4'd0);
    tick_n(20);
    set_cfg(1'b0, 4'd0);
    set_cfg(1'b1, 4'd0);
    tick_n(45);

    // R8: full FIFO drops the due repeat, next one a full period later
    cur_req = "R8";
    event_pulse(1'b1, 1'b0, 1'b1);
    tick_n(39);
    @(negedge clk) fifo_full = 1'b1;
    tick_n(1);
    @(negedge clk) fifo_full = 1'b0;
    tick_n(41);

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R4: queue left actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule